// File: doc/BRIEF.md
# Numerically Controlled Pulse Oscillator

This block is a phase accumulator that adds a programmable increment to itself on every enabled clock. Each time the sum passes the top of the accumulator range, the carry marks an output event. The carry is dropped and the remainder stays in the accumulator, so the long-term event rate is exactly `increment / 2^ACC_W` events per clock.

Each event drives one of two output shapes. In pulse mode the output goes high for a programmed number of clocks. In toggle mode the output flips on every event, which gives a square wave with a 50% duty cycle at half the event rate. A polarity input inverts the final output.

Increment writes are staged and applied at the next overflow, so an output period in progress is never cut short. Dropping the enable freezes the accumulator. Its value can then be read on `acc_value` and the count resumes from that value when the enable returns.

Top module: `nco_pulse_gen`

## Requirements
- R1: After reset the accumulator, the overflow strobe and the raw output are zero. On every clock edge with `enable` high, the accumulator becomes (accumulator + active increment) mod 2^ACC_W, and `acc_value` shows it.
- R2: An add that carries out of bit ACC_W-1 raises `ovf_strobe` for exactly the one cycle after that edge. The carry is discarded and the remainder is kept (for example, with a 16-bit accumulator, 0xC000 + 0xC000 leaves 0x8000).
- R3: While `enable` is low, the accumulator holds its value and no overflow strobe occurs. When `enable` returns, accumulation continues from the held value.
- R4: Pulse mode is `shape_sel`=0. The raw output is high for exactly `pulse_len` clocks, starting in the cycle after the overflow strobe.
- R5: In pulse mode, an overflow while a pulse is still high reloads the width count. The output stays high with no low gap.
- R6: Toggle mode is `shape_sel`=1. The raw output flips in the cycle after each overflow strobe, giving half the overflow rate.
- R7: A value written with `inc_write` becomes the active increment only on the clock edge where an overflow occurs. The exception is an active increment of zero: the written value then becomes active on the next clock edge, whether or not the block is enabled.
- R8: An active increment of zero produces no overflow strobe and no output activity.
- R9: With `invert` high, the output pin carries the complement of the raw output.
- R10: While `enable` is low, `nco_out` sits at its inactive level, which equals `invert`. This takes effect in the same cycle that `enable` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run (1) or freeze (0) |
| inc_value | input | ACC_W | New increment value |
| inc_write | input | 1 | Stage `inc_value` for the next overflow |
| shape_sel | input | 1 | 0 = pulse mode, 1 = toggle mode |
| pulse_len | input | PW_W | Pulse width in clocks (pulse mode) |
| invert | input | 1 | Invert the output polarity |
| acc_value | output | ACC_W | Current accumulator value |
| ovf_strobe | output | 1 | One-cycle strobe per overflow |
| nco_out | output | 1 | Shaped output |

## Verification
The accumulator is driven with several increments:
- 0xC000 overflows on almost every add, which separates keeping the remainder from clearing it.
- 0x3000 overflows at irregular points, which shows that the event count equals floor(N·inc/2^W).
- 0x0123 never overflows within the run and checks freeze and resume.
- Zero checks that the output stays idle.

For the output shapes:
- A pulse width shorter than the overflow period measures the pulse width and its start cycle.
- A width longer than the period must give a continuous high.
- In toggle mode, the 8-clock high and low runs confirm the half-rate square wave.
- Writing a new increment while running, with the accumulator partway to overflow, shows whether the write waits for the overflow or is applied at once.

// File: rtl/nco_pkg.sv
`timescale 1ns/1ps
package nco_pkg;

    typedef enum logic {
        SHAPE_PULSE  = 1'b0,
        SHAPE_TOGGLE = 1'b1
    } shape_e;

    // Accumulator widths the block is built for.
    function automatic bit acc_width_ok(int w);
        return (w == 16) || (w == 20);
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
`timescale 1ns/1ps
module nco_phase_acc #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [ACC_W-1:0] inc_value,
    input  logic             inc_write,
    output logic [ACC_W-1:0] acc_q,
    output logic             tick_q
);
    import nco_pkg::*;

    localparam int SUM_W = ACC_W + 1;

    generate
        if (!acc_width_ok(ACC_W)) begin : g_bad_width
            $error("nco_phase_acc: ACC_W must be 16 or 20");
        end
    endgenerate

    logic [ACC_W-1:0] inc_act;
    logic [ACC_W-1:0] inc_pend;
    logic             pend_v;
    logic [SUM_W-1:0] sum_c;
    logic             carry_c;
    logic             swap_c;

    always_comb begin
        sum_c   = {1'b0, acc_q} + {1'b0, inc_act};
        carry_c = enable & sum_c[ACC_W];
        swap_c  = pend_v & (carry_c | (inc_act == '0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            tick_q   <= 1'b0;
            inc_act  <= '0;
            inc_pend <= '0;
            pend_v   <= 1'b0;
        end else begin
            if (enable) begin
                acc_q <= sum_c[ACC_W-1:0];
            end
            tick_q <= carry_c;
            if (swap_c) begin
                inc_act <= inc_pend;
            end
            if (inc_write) begin
                inc_pend <= inc_value;
                pend_v   <= 1'b1;
            end else if (swap_c) begin
                pend_v <= 1'b0;
            end
        end
    end

    // R3
    acc_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(acc_q));

    // R2
    tick_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        tick_q |-> $past(enable));

    // R8
    zero_inc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (inc_act == '0) |=> !tick_q);

    // R7
    inc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((inc_act != '0) && !carry_c) |=> $stable(inc_act));

endmodule

// File: rtl/nco_shaper.sv
`timescale 1ns/1ps
module nco_shaper #(
    parameter int PW_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    input  logic            tick,
    input  nco_pkg::shape_e shape,
    input  logic [PW_W-1:0] pulse_len,
    output logic            raw_out
);
    import nco_pkg::*;

    logic [PW_W-1:0] width_cnt;
    logic            tgl_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            width_cnt <= '0;
            tgl_q     <= 1'b0;
        end else begin
            if (tick) begin
                width_cnt <= pulse_len;
            end else if (width_cnt != '0) begin
                width_cnt <= width_cnt - 1'b1;
            end
            if (tick && (shape == SHAPE_TOGGLE)) begin
                tgl_q <= ~tgl_q;
            end
        end
    end

    always_comb begin
        if (!enable) begin
            raw_out = 1'b0;
        end else if (shape == SHAPE_TOGGLE) begin
            raw_out = tgl_q;
        end else begin
            raw_out = (width_cnt != '0);
        end
    end

    // R4
    pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && tick && (shape == SHAPE_PULSE) && (pulse_len != '0))
        |=> (raw_out || !enable));

    // R6
    toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && tick && (shape == SHAPE_TOGGLE)) |=> (tgl_q != $past(tgl_q)));

    // R6
    toggle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && !tick) |=> $stable(tgl_q));

endmodule

// File: rtl/nco_pulse_gen.sv
`timescale 1ns/1ps
module nco_pulse_gen #(
    parameter int ACC_W = 16,
    parameter int PW_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [ACC_W-1:0] inc_value,
    input  logic             inc_write,
    input  logic             shape_sel,
    input  logic [PW_W-1:0]  pulse_len,
    input  logic             invert,
    output logic [ACC_W-1:0] acc_value,
    output logic             ovf_strobe,
    output logic             nco_out
);
    import nco_pkg::*;

    logic   tick;
    logic   raw;
    shape_e shape;

    assign shape = shape_e'(shape_sel);

    nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .inc_value (inc_value),
        .inc_write (inc_write),
        .acc_q     (acc_value),
        .tick_q    (tick)
    );

    nco_shaper #(.PW_W(PW_W)) u_shape (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .tick      (tick),
        .shape     (shape),
        .pulse_len (pulse_len),
        .raw_out   (raw)
    );

    assign ovf_strobe = tick;
    assign nco_out    = raw ^ invert;

    // R10
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (nco_out == invert));

    // R9
    polarity_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && (shape == SHAPE_PULSE) && ovf_strobe && (pulse_len != '0))
        |=> (nco_out != invert) || !enable);

endmodule

// File: tb/nco_pulse_gen_test.sv
`timescale 1ns/1ps
module nco_pulse_gen_test;

    localparam int ACC_W = 16;
    localparam int PW_W  = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enable = 1'b0;
    logic [ACC_W-1:0] inc_value = '0;
    logic             inc_write = 1'b0;
    logic             shape_sel = 1'b0;
    logic [PW_W-1:0]  pulse_len = '0;
    logic             invert = 1'b0;
    logic [ACC_W-1:0] acc_value;
    logic             ovf_strobe;
    logic             nco_out;

    int tests_run = 0;
    int tests_failed = 0;
    int ovf_cnt = 0;
    int idx = 0;
    logic samp [0:255];

    always #4 clk = ~clk;

    nco_pulse_gen #(.ACC_W(ACC_W), .PW_W(PW_W)) uut (
        .clk(clk), .rst(rst), .enable(enable), .inc_value(inc_value),
        .inc_write(inc_write), .shape_sel(shape_sel), .pulse_len(pulse_len),
        .invert(invert), .acc_value(acc_value), .ovf_strobe(ovf_strobe),
        .nco_out(nco_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests_run++;
        if (act != exp) begin
            tests_failed++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; enable = 1'b0; inc_write = 1'b0;
        shape_sel = 1'b0; invert = 1'b0; pulse_len = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        idx = 0; ovf_cnt = 0;
    endtask

    // Stage an increment while stopped; with a zero active increment it applies a clock later.
    task automatic load_inc(input logic [ACC_W-1:0] v);
        inc_value = v; inc_write = 1'b1;
        @(negedge clk);
        inc_write = 1'b0;
        @(negedge clk);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            idx++;
            samp[idx] = nco_out;
            if (ovf_strobe) ovf_cnt++;
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset acc", int'(acc_value), 0);
        check("R1 reset strobe", int'(ovf_strobe), 0);
        check("R1 reset out", int'(nco_out), 0);
    endtask

    task automatic t_accum();
        do_reset();
        load_inc(16'hC000);
        enable = 1'b1;
        step(1);
        check("R7 zero-active load applies", int'(acc_value), 'hC000);
        check("R2 no strobe before carry", int'(ovf_strobe), 0);
        step(1);
        check("R2 remainder kept", int'(acc_value), 'h8000);
        check("R2 strobe on carry", int'(ovf_strobe), 1);
        step(1);
        check("R2 second remainder", int'(acc_value), 'h4000);
        do_reset();
        load_inc(16'h3000);
        enable = 1'b1;
        ovf_cnt = 0;
        step(16);
        check("R1 acc after 16 adds", int'(acc_value), 0);
        check("R2 overflow count", ovf_cnt, 3);
    endtask

    task automatic t_freeze();
        do_reset();
        load_inc(16'h0123);
        enable = 1'b1;
        step(10);
        check("R3 run value", int'(acc_value), 'h0B5E);
        enable = 1'b0;
        ovf_cnt = 0;
        step(5);
        check("R3 frozen value", int'(acc_value), 'h0B5E);
        check("R3 no strobe frozen", ovf_cnt, 0);
        enable = 1'b1;
        step(3);
        check("R3 resume", int'(acc_value), 'h0EC7);
    endtask

    task automatic t_pulse();
        int first;
        int run;
        do_reset();
        shape_sel = 1'b0; pulse_len = 8'd3;
        load_inc(16'h1000);
        enable = 1'b1;
        idx = 0;
        step(40);
        first = 0;
        for (int i = 40; i >= 1; i--) if (samp[i] && !samp[i-1]) first = (i > 20) ? first : i;
        run = 0;
        for (int i = 17; i <= 24; i++) if (samp[i]) run++;
        check("R4 pulse start", first, 17);
        check("R4 pulse width", run, 3);
        check("R4 second pulse", int'(samp[33]) + int'(samp[32]) * 2, 1);
    endtask

    task automatic t_overlap();
        int lows;
        do_reset();
        shape_sel = 1'b0; pulse_len = 8'd20;
        load_inc(16'h1000);
        enable = 1'b1;
        idx = 0;
        step(50);
        lows = 0;
        for (int i = 17; i <= 48; i++) if (!samp[i]) lows++;
        check("R5 no gap on overlap", lows, 0);
        check("R5 idle before first event", int'(samp[16]), 0);
    endtask

    task automatic t_toggle();
        int highs;
        do_reset();
        shape_sel = 1'b1;
        load_inc(16'h2000);
        enable = 1'b1;
        idx = 0;
        step(32);
        highs = 0;
        for (int i = 9; i <= 16; i++) if (samp[i]) highs++;
        check("R6 low before first flip", int'(samp[8]), 0);
        check("R6 high run 8", highs, 8);
        check("R6 flips back", int'(samp[17]), 0);
        check("R6 flips again", int'(samp[25]), 1);
    endtask

    task automatic t_update();
        do_reset();
        load_inc(16'h4000);
        enable = 1'b1;
        step(1);
        inc_value = 16'h1000; inc_write = 1'b1;
        step(1);
        inc_write = 1'b0;
        check("R7 old inc continues", int'(acc_value), 'h8000);
        step(1);
        check("R7 held until overflow", int'(acc_value), 'hC000);
        step(1);
        check("R7 overflow edge", int'(acc_value), 0);
        step(1);
        check("R7 new inc after overflow", int'(acc_value), 'h1000);
    endtask

    task automatic t_zero();
        int highs;
        do_reset();
        shape_sel = 1'b0; pulse_len = 8'd4;
        enable = 1'b1;
        idx = 0; ovf_cnt = 0;
        step(60);
        highs = 0;
        for (int i = 1; i <= 60; i++) if (samp[i]) highs++;
        check("R8 zero inc strobes", ovf_cnt, 0);
        check("R8 zero inc output", highs, 0);
        check("R8 zero inc acc", int'(acc_value), 0);
    endtask

    task automatic t_polarity();
        do_reset();
        invert = 1'b1;
        @(negedge clk);
        check("R10 idle level inverted", int'(nco_out), 1);
        shape_sel = 1'b0; pulse_len = 8'd3;
        load_inc(16'h1000);
        enable = 1'b1;
        idx = 0;
        step(17);
        check("R9 inverted idle while running", int'(samp[16]), 1);
        check("R9 inverted pulse", int'(samp[17]), 0);
        enable = 1'b0;
        #1;
        check("R10 drop to idle at once", int'(nco_out), 1);
        do_reset();
        shape_sel = 1'b1;
        load_inc(16'h2000);
        enable = 1'b1;
        idx = 0;
        step(10);
        check("R10 toggle high before stop", int'(nco_out), 1);
        enable = 1'b0;
        #1;
        check("R10 toggle forced low", int'(nco_out), 0);
    endtask

    initial begin
        #(200000 * 8);
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        t_reset();
        t_accum();
        t_freeze();
        t_pulse();
        t_overlap();
        t_toggle();
        t_update();
        t_zero();
        t_polarity();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule